// File: doc/BRIEF.md
# Interrupting General-Purpose Pin Bank

This block is one bank of 32 general-purpose pins controlled from a 32-bit register bus. Software loads an output latch, picks each pin's direction, and reads back either the pin level after synchronization or the latch exactly as written. Each pin is modelled as three separate signals: an input bit, an output bit and an output-enable bit.

Every pin also has an event detector. Three configuration registers choose the trigger: a level-versus-edge select, a polarity select and a both-edges select. A detected event sets a sticky status bit. Software clears a status bit by writing a one to it. The enabled status bits are ORed into one interrupt line. Any bus access whose byte address has non-zero low two bits is ignored. Debouncing is done before the pins reach this block, and combining several banks is done outside it.

Top module: `pinbank_irq`

## Requirements
- R1: After a synchronous active-low reset, pin_out, pin_oe and irq are 0. Every register reads 0, including value (0x00), direction (0x04), latch (0x08) and status (0x20).
- R2: A write to offset 0x00 loads the output latch, and pin_out shows the new value after that clock edge. A read of offset 0x08 returns the latch exactly as written.
- R3: Offset 0x04 holds the direction bits, where 1 means output and 0 means input. pin_oe follows this register from the edge that writes it.
- R4: A read of offset 0x00 returns pin_in after a two-flop synchronizer, so a change becomes visible two clock edges later. This holds even for pins configured as outputs.
- R5: With level select (0x18) at 0, both-edges select (0x1C) at 0 and polarity (0x14) at 1, a rising synchronized edge sets the pin's status bit.
- R6: With level select at 0, both-edges select at 0 and polarity at 0, a falling synchronized edge sets the status bit, and a rising edge does not.
- R7: With level select at 0 and both-edges select at 1, either edge sets the status bit, whatever the polarity bit holds.
- R8: With level select at 1, the status bit is set on every cycle the synchronized level equals the polarity bit (1 means high, 0 means low). It stops being re-set once the level no longer matches.
- R9: Writing to status (0x20) clears each bit written as 1. Bits written as 0 are unchanged.
- R10: irq is the OR over all pins of status AND enable (0x10). Status still records events while enable is 0.
- R11: If an event arrives on the same edge as a write that clears its status bit, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not selected |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output latch driven to the pads |
| pin_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
A corrupted configuration or status flop shows up at the ports within three cycles of the pin change that should have set it. It appears as a wrong status readback or a wrong irq, because an event takes two synchronizer edges plus one capture edge to reach status. A stale previous-level flop shows as an extra or a missing edge event on the next transition of that pin. A clear that wins over a simultaneous event is visible on the very next status read. Latch and direction errors appear at pin_out and pin_oe one edge after the write.

// File: rtl/pinbank_pkg.sv
// Shared constants for the pin bank: register word indices on the bus.
// Assumes 32-bit registers on word-aligned byte addresses.
package pinbank_pkg;
    localparam int WORD_IDX_W = 4;
    localparam logic [WORD_IDX_W-1:0] IDX_VALUE  = 4'h0;  // 0x00
    localparam logic [WORD_IDX_W-1:0] IDX_DIR    = 4'h1;  // 0x04
    localparam logic [WORD_IDX_W-1:0] IDX_LATCH  = 4'h2;  // 0x08
    localparam logic [WORD_IDX_W-1:0] IDX_ENABLE = 4'h4;  // 0x10
    localparam logic [WORD_IDX_W-1:0] IDX_POL    = 4'h5;  // 0x14
    localparam logic [WORD_IDX_W-1:0] IDX_LEVEL  = 4'h6;  // 0x18
    localparam logic [WORD_IDX_W-1:0] IDX_BOTH   = 4'h7;  // 0x1C
    localparam logic [WORD_IDX_W-1:0] IDX_STATUS = 4'h8;  // 0x20
endpackage

// File: rtl/pinbank_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pin inputs.
// Assumes each bit is independent; no bus coherency is implied.
module pinbank_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [W-1:0] chain_q [STAGES];

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
        end else begin
            chain_q[0] <= d_in;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/pinbank_trig.sv
// Per-pin trigger detector. It compares the synchronized level with its value
// one cycle earlier and applies the level/polarity/both-edges selection.
// Assumes the input is already synchronous to clk.
module pinbank_trig #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_in,
    input  logic [W-1:0] pol_sel,
    input  logic [W-1:0] level_sel,
    input  logic [W-1:0] both_sel,
    output logic [W-1:0] evt
);
    logic [W-1:0] prev_q;

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_in;
    end

    for (genvar p = 0; p < W; p++) begin : g_pin
        logic rise, fall;
        assign rise = lvl_in[p] & ~prev_q[p];
        assign fall = ~lvl_in[p] & prev_q[p];
        // Select the trigger condition for this pin.
        always_comb begin
            if (level_sel[p])     evt[p] = (lvl_in[p] == pol_sel[p]);
            else if (both_sel[p]) evt[p] = rise | fall;
            else if (pol_sel[p])  evt[p] = rise;
            else                  evt[p] = fall;
        end
    end
endmodule

// File: rtl/pinbank_status.sv
// Sticky event status with write-one-to-clear. A new event wins over a
// clear on the same edge. Assumes clr is a one-cycle pulse mask.
module pinbank_status #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] clr,
    output logic [W-1:0] status_q
);
    // Clear the requested bits, then OR in the new events.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr) | evt;
    end
endmodule

// File: rtl/pinbank_irq.sv
// One bank of general-purpose pins with output latch, direction control,
// synchronized readback and per-pin interrupt detection.
// Assumes a single-cycle register bus: writes take effect on the edge that
// samples bus_sel && bus_we, and reads are combinational. Accesses with a
// non-zero byte offset inside a word are ignored.
module pinbank_irq #(
    parameter int W  = 32,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    input  logic [W-1:0]  pin_in,
    output logic [W-1:0]  pin_out,
    output logic [W-1:0]  pin_oe,
    output logic          irq
);
    import pinbank_pkg::*;

    localparam int IDX_W = AW - 2;

    logic [W-1:0]     latch_q, dir_q, en_q, pol_q, level_q, both_q;
    logic [W-1:0]     sync_lvl, evt_vec, clr_mask, status_q;
    logic [IDX_W-1:0] word_idx;
    logic             acc_ok, wr_en;

    assign word_idx = bus_addr[AW-1:2];
    assign acc_ok   = bus_sel && (bus_addr[1:0] == 2'b00);
    assign wr_en    = acc_ok && bus_we;

    // Configuration and latch registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
            en_q    <= '0;
            pol_q   <= '0;
            level_q <= '0;
            both_q  <= '0;
        end else if (wr_en) begin
            case (word_idx)
                IDX_W'(IDX_VALUE):  latch_q <= bus_wdata;
                IDX_W'(IDX_DIR):    dir_q   <= bus_wdata;
                IDX_W'(IDX_ENABLE): en_q    <= bus_wdata;
                IDX_W'(IDX_POL):    pol_q   <= bus_wdata;
                IDX_W'(IDX_LEVEL):  level_q <= bus_wdata;
                IDX_W'(IDX_BOTH):   both_q  <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Write-one-to-clear mask for the status register.
    assign clr_mask = (wr_en && word_idx == IDX_W'(IDX_STATUS)) ? bus_wdata : '0;

    pinbank_sync #(.W(W), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(pin_in), .q_out(sync_lvl)
    );

    pinbank_trig #(.W(W)) u_trig (
        .clk(clk), .rst_n(rst_n), .lvl_in(sync_lvl), .pol_sel(pol_q),
        .level_sel(level_q), .both_sel(both_q), .evt(evt_vec)
    );

    pinbank_status #(.W(W)) u_status (
        .clk(clk), .rst_n(rst_n), .evt(evt_vec), .clr(clr_mask), .status_q(status_q)
    );

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (acc_ok) begin
            case (word_idx)
                IDX_W'(IDX_VALUE):  bus_rdata = sync_lvl;
                IDX_W'(IDX_DIR):    bus_rdata = dir_q;
                IDX_W'(IDX_LATCH):  bus_rdata = latch_q;
                IDX_W'(IDX_ENABLE): bus_rdata = en_q;
                IDX_W'(IDX_POL):    bus_rdata = pol_q;
                IDX_W'(IDX_LEVEL):  bus_rdata = level_q;
                IDX_W'(IDX_BOTH):   bus_rdata = both_q;
                IDX_W'(IDX_STATUS): bus_rdata = status_q;
                default:            bus_rdata = '0;
            endcase
        end
    end

    assign pin_out = latch_q;
    assign pin_oe  = dir_q;
    assign irq     = |(status_q & en_q);
endmodule

// File: rtl/pinbank_irq_chk.sv
// Property checker for the pin bank, attached to every instance by bind.
// Assumes the same parameters as the checked instance.
module pinbank_irq_chk #(
    parameter int W  = 32,
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [W-1:0]  bus_wdata,
    input logic [W-1:0]  pin_out,
    input logic [W-1:0]  pin_oe,
    input logic          irq,
    input logic [W-1:0]  status_q,
    input logic [W-1:0]  evt_vec,
    input logic [W-1:0]  clr_mask
);
    logic wr_value, wr_dir, wr_en_zero;
    assign wr_value   = bus_sel && bus_we && bus_addr == AW'(6'h00);
    assign wr_dir     = bus_sel && bus_we && bus_addr == AW'(6'h04);
    assign wr_en_zero = bus_sel && bus_we && bus_addr == AW'(6'h10) && bus_wdata == '0;

    assert_latch_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_value |=> pin_out == $past(bus_wdata));

    assert_dir_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> pin_oe == $past(bus_wdata));

    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_zero |=> !irq);

    assert_clear_only_by_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status_q) & ~$past(clr_mask) & ~status_q) == '0));

    assert_event_survives_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(evt_vec) & ~status_q) == '0));

    assert_set_only_by_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt_vec)) == '0));
endmodule

bind pinbank_irq pinbank_irq_chk #(.W(W), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq), .status_q(status_q), .evt_vec(evt_vec),
    .clr_mask(clr_mask)
);

// File: tb/pinbank_irq_bench.sv
// Directed bench for the pin bank: one task per scenario, each checking itself.
module pinbank_irq_bench;
    localparam int W = 32;
    localparam int AW = 6;
    localparam logic [AW-1:0] A_VAL = 6'h00, A_DIR = 6'h04, A_LAT = 6'h08,
        A_EN = 6'h10, A_POL = 6'h14, A_LVL = 6'h18, A_BOTH = 6'h1C, A_STAT = 6'h20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0, bus_rdata;
    logic [W-1:0]  pin_in = '0, pin_out, pin_oe;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pinbank_irq #(.W(W), .AW(AW)) u_pinbank_irq (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [W-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [W-1:0] d;
        check("R1 pin_out", pin_out, '0);
        check("R1 pin_oe", pin_oe, '0);
        check("R1 irq", {31'b0, irq}, '0);
        bus_read(A_VAL, d);  check("R1 value", d, '0);
        bus_read(A_LAT, d);  check("R1 latch", d, '0);
        bus_read(A_STAT, d); check("R1 status", d, '0);
    endtask

    task automatic t_latch_dir;
        logic [W-1:0] d;
        bus_write(A_VAL, 32'hA5A5_0F0F);
        check("R2 pin_out", pin_out, 32'hA5A5_0F0F);
        bus_read(A_LAT, d); check("R2 latch readback", d, 32'hA5A5_0F0F);
        bus_write(A_DIR, 32'hFFFF_0000);
        check("R3 pin_oe", pin_oe, 32'hFFFF_0000);
        bus_read(A_DIR, d); check("R3 dir readback", d, 32'hFFFF_0000);
    endtask

    task automatic t_sync_read;
        logic [W-1:0] d;
        @(negedge clk);
        pin_in = 32'h1234_5678;
        bus_read(A_VAL, d); check("R4 one edge", d, '0);
        bus_read(A_VAL, d); check("R4 two edges", d, 32'h1234_5678);
        pin_in = '0;
        settle(4);
    endtask

    task automatic t_triggers;
        logic [W-1:0] d;
        // pin0 rise, pin1 fall, pin2/3 both, pin4 level high, pin5 level low
        bus_write(A_POL, 32'h19);
        bus_write(A_LVL, 32'h30);
        bus_write(A_BOTH, 32'h0C);
        settle(4);
        bus_write(A_STAT, 32'hFFFF_FFFF);
        bus_read(A_STAT, d); check("R8 level low held", d, 32'h20);
        @(negedge clk); pin_in = 32'h1D; settle(4);
        bus_read(A_STAT, d); check("R5 R7 R8 rise events", d, 32'h3D);
        check("R10 masked irq", {31'b0, irq}, '0);
        bus_write(A_STAT, 32'h3D);
        bus_read(A_STAT, d); check("R8 level re-sets after clear", d, 32'h30);
        bus_write(A_STAT, 32'h0);
        bus_read(A_STAT, d); check("R9 zero write no effect", d, 32'h30);
        @(negedge clk); pin_in = 32'h12; settle(4);
        bus_read(A_STAT, d); check("R7 fall events, R5 R6 ignore", d, 32'h3C);
        @(negedge clk); pin_in = 32'h10; settle(4);
        bus_read(A_STAT, d); check("R6 falling edge", d, 32'h3E);
        @(negedge clk); pin_in = 32'h20; settle(4);
        bus_write(A_STAT, 32'hFF);
        bus_read(A_STAT, d); check("R8 level released", d, 32'h0);
    endtask

    task automatic t_irq;
        logic [W-1:0] d;
        bus_write(A_EN, 32'h1);
        check("R10 idle irq", {31'b0, irq}, '0);
        pin_in = 32'h21;
        @(negedge clk); @(negedge clk);
        check("R10 irq before capture", {31'b0, irq}, '0);
        @(negedge clk);
        check("R10 irq raised", {31'b0, irq}, 32'h1);
        bus_write(A_EN, 32'h0);
        check("R10 irq masked", {31'b0, irq}, '0);
        bus_write(A_EN, 32'h1);
        check("R10 irq unmasked", {31'b0, irq}, 32'h1);
        bus_write(A_STAT, 32'h1);
        check("R9 irq after clear", {31'b0, irq}, '0);
        bus_read(A_STAT, d); check("R9 status cleared", d, '0);
    endtask

    task automatic t_collision;
        logic [W-1:0] d;
        @(negedge clk); pin_in = 32'h20; settle(4);
        @(negedge clk); pin_in = 32'h21;
        @(negedge clk);
        bus_write(A_STAT, 32'h1);
        bus_read(A_STAT, d); check("R11 event beats clear", d, 32'h1);
        bus_write(A_STAT, 32'h1);
        bus_read(A_STAT, d); check("R11 later clear works", d, 32'h0);
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        settle(3);
        rst_n = 1'b1;
        settle(1);
        t_reset();
        t_latch_dir();
        t_sync_read();
        t_triggers();
        t_irq();
        t_collision();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule